// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel for a programmable interval timer. A count-enable tick advances it; a load strobe delivers a new initial count together with a counting mode and a choice of binary or four-digit decimal (BCD) counting. It presents the live counter value to a separate host interface block and drives one output pin whose waveform depends on the mode. The supported modes are: terminal-count flag, gate-triggered one-shot, rate generator, square wave, software strobe and gate-triggered strobe.

The counter is a `CountWidth`-bit register that holds either a plain binary value or `CountWidth/4` BCD digits. An initial count of zero selects the full range. The one-shot style modes wrap when they pass zero. The two periodic modes reload at the end of each period. The gate input either pauses counting or, on a rising edge, restarts it, depending on the mode.

Top module: `intervalCounterChannel`

## Requirements
- R1: After reset, and until the first load strobe, countValue is 0 and outPin is low whatever tickEn and gate do.
- R2: An initial count of 0 acts as 65536 ticks in binary counting and as 10000 ticks in BCD counting (default width of 16 bits).
- R3: In modes 0, 1, 4 and 5 the counter keeps decrementing past zero: binary code 0 is followed by FFFF hex and BCD code 0000 by 9999.
- R4: Modes 2 and 3 are periodic: with count N the counter walks N, N-1, ..., 1 and then reloads. A load in the same periodic mode with the same encoding while running does not disturb the current period; the new value is used from the next reload on.
- R5: The mode is modeSel[2:0]; code 6 behaves exactly as mode 2 and code 7 exactly as mode 3.
- R6: A rising edge on gate restarts counting from the stored initial count in modes 1, 2, 3 and 5, and gate level does not pause them. In modes 0 and 4 a low gate holds the counter and a rising edge does not restart it.
- R7: In mode 3 with count N, outPin is high for the first ceil(N/2) ticks of each period and low for the remaining floor(N/2).
- R8: In mode 2 outPin is low on loading and goes high for one tick interval each time a full period of N ticks has elapsed.
- R9: In mode 0 outPin goes high when N ticks have elapsed and stays high until the next load; in modes 4 and 5 it goes high for exactly one tick interval at the N-th tick and never again before the next start.
- R10: With bcdSel = 1 each 4-bit nibble counts down in decimal: a nibble at 0 that is decremented becomes 9 and borrows from the next nibble up.
- R11: A load in modes 0, 1, 4 or 5 restarts counting at once from the new value; in mode 0 outPin is driven low at that point.
- R12: In mode 1 outPin is high from the start until N ticks have elapsed, then low until the next start.
- R13: In one clock cycle a load strobe takes precedence over a gate restart, and a gate restart takes precedence over a tick; the lower-priority event is dropped for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-enable tick, one cycle per count step |
| gate | input | 1 | Gate level, pause or restart depending on mode |
| loadStrobe | input | 1 | Takes loadValue, modeSel and bcdSel |
| loadValue | input | CountWidth | Initial count; 0 selects the full range |
| modeSel | input | 3 | Counting mode, codes 0 to 7 |
| bcdSel | input | 1 | 1 selects BCD counting |
| countValue | output | CountWidth | Live counter value in the selected encoding |
| outPin | output | 1 | Channel output waveform |

## Verification
The delicate coincidence is a tick arriving in the same cycle as a restart, either from a load strobe or from a gate rising edge. A dropped priority would shift every later count by one step. The bench provokes both cases in the rate-generator mode with a tick, a gate edge and a load all asserted on one edge. It also provokes a deferred same-mode load that lands on a tick. Against an arithmetic model of elapsed ticks, it then checks that the counter shows the restarted value, or the unchanged value, on the following cycles rather than a decremented one.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    MODE_TERM     = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } cntMode_e;

  // Strobes from the control to the datapath, at most one action per cycle
  typedef struct packed {
    logic takeLoad;   // store loadValue as the pending initial count
    logic startNow;   // restart counting from the initial count
    logic stepDown;   // decrement by one
    logic reloadNow;  // end of a period, reload from the pending count
  } ctrlStrobe_t;

  // Codes 6 and 7 fold onto the two periodic modes
  function automatic cntMode_e normMode(input logic [2:0] raw);
    if (raw[2] && raw[1]) return cntMode_e'({1'b0, raw[1:0]});
    return cntMode_e'(raw);
  endfunction

  function automatic logic isPeriodic(input cntMode_e m);
    return (m == MODE_RATE) || (m == MODE_SQUARE);
  endfunction

endpackage

// File: rtl/ictr_datapath.sv
module ictr_datapath
  import ictr_pkg::*;
#(
  parameter int CountWidth = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [CountWidth-1:0] loadValue,
  input  logic                  bcdSel,
  output logic [CountWidth-1:0] countValue,
  output logic                  atOne,
  output logic                  bcdNow,
  output logic                  sqHigh
);

  localparam int Digits = CountWidth / 4;
  localparam int ExtW   = CountWidth + 1;
  localparam logic [ExtW-1:0] BinFull = ExtW'(1) << CountWidth;
  localparam logic [ExtW-1:0] DecFull = ExtW'(10 ** Digits);

  logic [CountWidth-1:0] cntQ, pendQ, activeQ;
  logic                  bcdQ;

  // Digit-wise decimal decrement with a borrow chain
  logic [Digits-1:0]     borrow;
  logic [Digits-1:0]     nibOk;
  logic [CountWidth-1:0] bcdDec;
  logic [CountWidth-1:0] binDec;
  logic [CountWidth-1:0] decVal;
  logic                  digitsValid;

  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < Digits; i++) begin : g_digit
    logic [3:0] nib;
    assign nib = cntQ[4*i +: 4];
    assign nibOk[i] = (nib <= 4'd9);
    assign bcdDec[4*i +: 4] = !borrow[i] ? nib :
                              ((nib == 4'd0) ? 4'd9 : nib - 4'd1);
    if (i < Digits - 1) begin : g_chain
      assign borrow[i+1] = borrow[i] && (nib == 4'd0);
    end
  end

  assign binDec      = cntQ - CountWidth'(1);
  assign decVal      = bcdQ ? bcdDec : binDec;
  assign digitsValid = &nibOk;

  // Magnitude of a code, with code 0 standing for the full range
  function automatic logic [ExtW-1:0] toMagnitude(input logic [CountWidth-1:0] v,
                                                  input logic isBcd);
    logic [ExtW-1:0] acc;
    acc = '0;
    if (!isBcd) begin
      acc = {1'b0, v};
    end else begin
      for (int i = Digits - 1; i >= 0; i--) begin
        acc = acc * ExtW'(10) + ExtW'(v[4*i +: 4]);
      end
    end
    if (acc == '0) acc = isBcd ? DecFull : BinFull;
    return acc;
  endfunction

  logic [ExtW-1:0] cntMag, activeMag;
  assign cntMag    = toMagnitude(cntQ, bcdQ);
  assign activeMag = toMagnitude(activeQ, bcdQ);
  assign sqHigh    = cntMag > (activeMag >> 1);

  logic [CountWidth-1:0] startSrc;
  assign startSrc = strobe.takeLoad ? loadValue : pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      pendQ   <= '0;
      activeQ <= '0;
      bcdQ    <= 1'b0;
    end else begin
      if (strobe.startNow) begin
        cntQ    <= startSrc;
        activeQ <= startSrc;
        if (strobe.takeLoad) bcdQ <= bcdSel;
      end else if (strobe.reloadNow) begin
        cntQ    <= pendQ;
        activeQ <= pendQ;
      end else if (strobe.stepDown) begin
        cntQ <= decVal;
      end
      if (strobe.takeLoad) pendQ <= loadValue;
    end
  end

  assign countValue = cntQ;
  assign atOne      = (cntQ == CountWidth'(1));
  assign bcdNow     = bcdQ;

  // R10: a plain decimal step keeps every digit in the range 0 to 9
  p_bcd_digits_r10: assert property (@(posedge clk) disable iff (!rstN)
    (bcdQ && digitsValid && strobe.stepDown && !strobe.reloadNow && !strobe.startNow)
      |=> digitsValid);

endmodule

// File: rtl/ictr_control.sv
module ictr_control
  import ictr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        gate,
  input  logic        loadStrobe,
  input  logic [2:0]  modeSel,
  input  logic        bcdSel,
  input  logic        atOne,
  input  logic        sqHigh,
  input  logic        bcdNow,
  output ctrlStrobe_t strobe,
  output cntMode_e    modeNow,
  output logic        loadedNow,
  output logic        outPin
);

  cntMode_e modeQ;
  logic     loadedQ, gatePrevQ, doneQ, outQ;

  cntMode_e newMode, startMode;
  logic     gateRise, levelGated, edgeRestart, deferLoad;

  assign newMode     = normMode(modeSel);
  assign gateRise    = gate && !gatePrevQ;
  assign levelGated  = (modeQ == MODE_TERM) || (modeQ == MODE_SWSTROBE);
  assign edgeRestart = (modeQ == MODE_ONESHOT) || (modeQ == MODE_HWSTROBE) ||
                       isPeriodic(modeQ);
  assign deferLoad   = loadedQ && isPeriodic(modeQ) && (newMode == modeQ) &&
                       (bcdSel == bcdNow);

  // Priority: load, then gate restart, then tick
  always_comb begin
    strobe = '0;
    if (loadStrobe) begin
      strobe.takeLoad = 1'b1;
      strobe.startNow = !deferLoad;
    end else if (loadedQ && gateRise && edgeRestart) begin
      strobe.startNow = 1'b1;
    end else if (loadedQ && tickEn && (gate || !levelGated)) begin
      strobe.stepDown  = 1'b1;
      strobe.reloadNow = isPeriodic(modeQ) && atOne;
    end
  end

  assign startMode = strobe.takeLoad ? newMode : modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_TERM;
      loadedQ   <= 1'b0;
      gatePrevQ <= 1'b0;
      doneQ     <= 1'b0;
      outQ      <= 1'b0;
    end else begin
      gatePrevQ <= gate;
      if (strobe.takeLoad) loadedQ <= 1'b1;
      if (strobe.startNow) begin
        modeQ <= startMode;
        doneQ <= 1'b0;
        outQ  <= (startMode == MODE_ONESHOT);
      end else if (strobe.stepDown) begin
        case (modeQ)
          MODE_RATE:   outQ <= atOne;
          MODE_SQUARE: outQ <= 1'b0;
          default: begin
            if (atOne && !doneQ) begin
              doneQ <= 1'b1;
              outQ  <= (modeQ != MODE_ONESHOT);
            end else if ((modeQ == MODE_SWSTROBE) || (modeQ == MODE_HWSTROBE)) begin
              outQ <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign outPin    = (loadedQ && (modeQ == MODE_SQUARE)) ? sqHigh : outQ;
  assign modeNow   = modeQ;
  assign loadedNow = loadedQ;

  // R9: the terminal flag of mode 0 holds until a load
  p_mode0_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_TERM && outQ && !loadStrobe) |=> outQ);

  // R9: a strobe lasts one counting tick
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_SWSTROBE || modeQ == MODE_HWSTROBE) && outQ && strobe.stepDown)
      |=> !outQ);

  // R8: loading the rate generator never pulses the output
  p_no_load_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.startNow && strobe.takeLoad && newMode == MODE_RATE) |=> !outPin);

endmodule

// File: rtl/intervalCounterChannel.sv
module intervalCounterChannel
  import ictr_pkg::*;
#(
  parameter int CountWidth = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  gate,
  input  logic                  loadStrobe,
  input  logic [CountWidth-1:0] loadValue,
  input  logic [2:0]            modeSel,
  input  logic                  bcdSel,
  output logic [CountWidth-1:0] countValue,
  output logic                  outPin
);

  ctrlStrobe_t strobe;
  cntMode_e    modeNow;
  logic        loadedNow, atOne, sqHigh, bcdNow;

  ictr_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .gate       (gate),
    .loadStrobe (loadStrobe),
    .modeSel    (modeSel),
    .bcdSel     (bcdSel),
    .atOne      (atOne),
    .sqHigh     (sqHigh),
    .bcdNow     (bcdNow),
    .strobe     (strobe),
    .modeNow    (modeNow),
    .loadedNow  (loadedNow),
    .outPin     (outPin)
  );

  ictr_datapath #(.CountWidth(CountWidth)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loadValue  (loadValue),
    .bcdSel     (bcdSel),
    .countValue (countValue),
    .atOne      (atOne),
    .bcdNow     (bcdNow),
    .sqHigh     (sqHigh)
  );

  // R6: a low gate freezes the counter in the level-gated modes
  p_gated_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loadedNow && (modeNow == MODE_TERM || modeNow == MODE_SWSTROBE) &&
     !gate && !loadStrobe) |=> $stable(countValue));

  // R1: nothing leaves the idle state before the first load
  p_idle_out_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!loadedNow && !loadStrobe) |=> (countValue == '0 && !outPin));

endmodule

// File: tb/sim_intervalCounterChannel.sv
module sim_intervalCounterChannel;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        gate = 1'b1;
  logic        loadStrobe = 1'b0;
  logic [15:0] loadValue = '0;
  logic [2:0]  modeSel = '0;
  logic        bcdSel = 1'b0;
  logic [15:0] countValue;
  logic        outPin;

  int vecCount  = 0;
  int failCount = 0;

  // Reference state
  bit mLoaded = 0;
  int mMode = 0;
  bit mBcd = 0;
  int mPend = 0, mActive = 0, mD = 0, mK = 0;
  bit mGatePrev = 0;

  always #(ClkPeriod/2) clk = ~clk;

  intervalCounterChannel u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gate(gate),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .modeSel(modeSel),
    .bcdSel(bcdSel), .countValue(countValue), .outPin(outPin)
  );

  function automatic int bcdToInt(input int raw);
    return ((raw >> 12) & 15) * 1000 + ((raw >> 8) & 15) * 100 +
           ((raw >> 4) & 15) * 10 + (raw & 15);
  endfunction

  function automatic int intToBcd(input int v);
    return ((v / 1000) % 10) << 12 | ((v / 100) % 10) << 8 |
           ((v / 10) % 10) << 4 | (v % 10);
  endfunction

  function automatic int effN(input int raw, input bit b);
    if (raw == 0) return b ? 10000 : 65536;
    return b ? bcdToInt(raw) : raw;
  endfunction

  function automatic int expCount();
    int modulus, v;
    modulus = mBcd ? 10000 : 65536;
    if (!mLoaded) return 0;
    if (mMode == 2 || mMode == 3)
      v = (effN(mActive, mBcd) - mK) % modulus;
    else
      v = (((mBcd ? bcdToInt(mActive) : mActive) - mD) % modulus + modulus) % modulus;
    return mBcd ? intToBcd(v) : v;
  endfunction

  function automatic bit expOut();
    int n;
    if (!mLoaded) return 1'b0;
    n = effN(mActive, mBcd);
    case (mMode)
      0: return mD >= n;
      1: return mD < n;
      2: return (mK == 0) && (mD > 0);
      3: return mK < (n + 1) / 2;
      default: return mD == n;
    endcase
  endfunction

  task automatic modelStep(input bit tk, input bit gt, input bit ld,
                           input int val, input int md, input bit bc);
    int nm;
    nm = (md >= 6) ? md - 4 : md;
    if (ld) begin
      if (mLoaded && (mMode == 2 || mMode == 3) && nm == mMode && bc == mBcd) begin
        mPend = val;
      end else begin
        mMode = nm; mBcd = bc; mPend = val; mActive = val; mD = 0; mK = 0;
      end
      mLoaded = 1;
    end else if (mLoaded && gt && !mGatePrev &&
                 (mMode == 1 || mMode == 2 || mMode == 3 || mMode == 5)) begin
      mActive = mPend; mD = 0; mK = 0;
    end else if (mLoaded && tk && (gt || !(mMode == 0 || mMode == 4))) begin
      mD++;
      if (mMode == 2 || mMode == 3) begin
        mK++;
        if (mK == effN(mActive, mBcd)) begin
          mK = 0;
          mActive = mPend;
        end
      end
    end
    mGatePrev = gt;
  endtask

  task automatic compare(input string tag);
    int ec;
    bit eo;
    ec = expCount();
    eo = expOut();
    vecCount++;
    if (countValue !== 16'(ec) || outPin !== eo) begin
      failCount++;
      $display("FAIL %s t=%0t count=%h exp=%h out=%b exp=%b",
               tag, $time, countValue, 16'(ec), outPin, eo);
    end
  endtask

  // One clock: drive at the falling edge, sample a quarter period after the rising edge
  task automatic cyc(input bit tk, input bit gt, input bit ld, input int val,
                     input int md, input bit bc, input string tag);
    @(negedge clk);
    tickEn = tk; gate = gt; loadStrobe = ld;
    loadValue = 16'(val); modeSel = 3'(md); bcdSel = bc;
    @(posedge clk);
    modelStep(tk, gt, ld, val, md, bc);
    #(ClkPeriod/4);
    compare(tag);
  endtask

  task automatic run(input int n, input bit gt, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, gt, 1'b0, 0, 0, 1'b0, tag);
  endtask

  task automatic loadCnt(input int val, input int md, input bit bc, input string tag);
    cyc(1'b0, 1'b1, 1'b1, val, md, bc, tag);
  endtask

  initial begin
    #(ClkPeriod * 190000);
    failCount++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1 compare("R1");
    run(4, 1'b1, "R1");

    // Mode 0: terminal flag, wrap, reload
    loadCnt(5, 0, 1'b0, "R11");
    run(8, 1'b1, "R9");
    run(4, 1'b1, "R3");
    loadCnt(3, 0, 1'b0, "R11");
    run(2, 1'b1, "R11");
    run(3, 1'b0, "R6");
    cyc(1'b1, 1'b1, 1'b0, 0, 0, 1'b0, "R6");
    run(3, 1'b1, "R9");

    // Mode 1
    loadCnt(4, 1, 1'b0, "R12");
    run(6, 1'b1, "R12");
    cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R6");
    cyc(1'b1, 1'b1, 1'b0, 0, 0, 1'b0, "R6");
    run(6, 1'b1, "R12");

    // Mode 2, deferred load, gate behaviour
    loadCnt(4, 2, 1'b0, "R8");
    run(10, 1'b1, "R8");
    loadCnt(6, 2, 1'b0, "R4");
    run(14, 1'b1, "R4");
    run(3, 1'b0, "R6");
    cyc(1'b1, 1'b1, 1'b0, 0, 0, 1'b0, "R6");
    run(4, 1'b1, "R8");

    // Mode 3, odd and even counts
    loadCnt(5, 3, 1'b0, "R7");
    run(12, 1'b1, "R7");
    loadCnt(6, 3, 1'b0, "R4");
    run(14, 1'b1, "R7");

    // Strobes
    loadCnt(3, 4, 1'b0, "R9");
    run(2, 1'b1, "R9");
    run(2, 1'b0, "R6");
    run(4, 1'b1, "R9");
    loadCnt(3, 5, 1'b0, "R9");
    run(5, 1'b1, "R9");
    cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R6");
    cyc(1'b1, 1'b1, 1'b0, 0, 0, 1'b0, "R6");
    run(5, 1'b1, "R9");

    // Mode aliases
    loadCnt(3, 6, 1'b0, "R5");
    run(7, 1'b1, "R5");
    loadCnt(4, 7, 1'b0, "R5");
    run(9, 1'b1, "R5");

    // BCD counting
    loadCnt(16'h0012, 0, 1'b1, "R10");
    run(20, 1'b1, "R3");
    loadCnt(16'h0105, 1, 1'b1, "R10");
    run(12, 1'b1, "R10");
    loadCnt(16'h0007, 3, 1'b1, "R10");
    run(10, 1'b1, "R7");

    // Same-cycle coincidences
    loadCnt(4, 2, 1'b0, "R13");
    run(2, 1'b1, "R13");
    cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R13");
    cyc(1'b1, 1'b1, 1'b1, 9, 1, 1'b0, "R13");
    run(3, 1'b1, "R13");
    loadCnt(4, 2, 1'b0, "R13");
    run(2, 1'b1, "R13");
    cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0, "R13");
    cyc(1'b1, 1'b1, 1'b0, 0, 0, 1'b0, "R13");
    run(2, 1'b1, "R13");
    cyc(1'b1, 1'b1, 1'b1, 5, 2, 1'b0, "R13");
    run(8, 1'b1, "R4");

    // Full-range counts
    loadCnt(0, 2, 1'b0, "R2");
    run(65540, 1'b1, "R2");
    loadCnt(0, 2, 1'b1, "R2");
    run(10005, 1'b1, "R2");

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule